// File: doc/BRIEF.md
# Manchester Nibble Codec

This block carries the 10 Mb/s digital data path between a 4-bit nibble interface and a Manchester-coded serial line. It runs on a single chip-rate clock (nominally 20 MHz), so one nibble period is eight clock cycles, which is the 2.5 MHz nibble rate. On the transmit side a nibble is captured at a nibble boundary. It is sent least significant bit first, and each bit becomes two half-bit chips on the line. When transmit enable is withdrawn, the nibble in flight is finished and the line then rests low.

On the receive side the block takes a chip stream that is already aligned to chip boundaries, together with a framing signal that marks valid data. It pairs the chips and decodes each pair into a bit. It fills a nibble least significant bit first. Each completed nibble is presented for one full nibble period with a valid flag. A pair whose two chips are equal is a code violation, and the nibble that contains it is flagged as invalid. When the framing signal drops, any partly assembled nibble is thrown away and the chip pairing starts again from the next framed chip.

Top module: `manch_nibble_codec`

## Requirements
- R1: `tx_take` is high exactly when `tx_en` is high and the transmitter is idle or is on the last (eighth) chip of the current nibble; the nibble on `tx_nibble` is captured at that clock edge.
- R2: A captured nibble leaves on `line_tx` as 8 chips, one per clock, starting the cycle after capture, bit 0 first and bit 3 last, two chips per bit.
- R3: A bit value 1 is sent as chip 0 then chip 1, and a bit value 0 is sent as chip 1 then chip 0.
- R4: If `tx_en` falls part way through a nibble, all 8 chips of that nibble are still sent; afterwards `line_tx` stays 0 and `tx_take` stays 0 while `tx_en` is low.
- R5: Changes on `tx_nibble` outside the capture edge have no effect on the chips of the nibble being sent.
- R6: With `tx_en` held high, consecutive nibbles follow each other with no idle chip between them.
- R7: While `rx_dv` is high, chips are paired in arrival order (the first framed chip opens a pair); a pair (0,1) decodes to 1, and (1,0) decodes to 0. Four pairs fill `rx_nibble` bit 0 first.
- R8: One cycle after the eighth framed chip of a nibble, `rx_valid` rises. It stays high for exactly 8 cycles, and `rx_nibble` and `rx_err` hold steady in that window unless the next nibble completes.
- R9: A pair with two equal chips sets `rx_err` to 1 for the nibble that contains it; the next nibble with no violation shows `rx_err` 0.
- R10: A low cycle on `rx_dv` discards a partly assembled nibble and any violation recorded in it; no `rx_valid` results from the partial data.
- R11: After reset, `line_tx`, `rx_valid`, `rx_err` and `rx_nibble` are 0, and `tx_take` is 0 while `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, sampled at nibble boundaries |
| tx_nibble | input | 4 | Nibble to transmit |
| tx_take | output | 1 | Nibble is captured at this clock edge |
| line_tx | output | 1 | Manchester chip output, low when idle |
| rx_dv | input | 1 | Receive framing, high while chips are valid |
| rx_chip | input | 1 | Chip-aligned received chip |
| rx_nibble | output | 4 | Last completed received nibble |
| rx_valid | output | 1 | High for one nibble period per completed nibble |
| rx_err | output | 1 | Completed nibble contained a code violation |

## Verification
A wrong transmit phase count or a bad shift register shows up within one nibble period. On `line_tx` it appears as a chip pair that does not alternate, as bits in the wrong order, or as a gap or extra chip between nibbles. It also shifts the cycle in which `tx_take` appears. On the receive side, a pair counter that is out of step turns clean data into wrong nibbles with `rx_err` set. It shows as soon as the first nibble after the slip completes, eight cycles after framing starts. A stale violation or a partial nibble that was kept past a drop in framing shows on the next `rx_err` or `rx_valid`. A wrong stretch count shows when `rx_valid` falls one cycle early or late.

// File: rtl/manch_codec_pkg.sv
package manch_codec_pkg;

  // Line chip for one half of a bit: first half carries the inverse,
  // second half carries the bit itself.
  function automatic logic manch_chip(input logic bit_val, input logic second_half);
    return second_half ? bit_val : ~bit_val;
  endfunction

  // Decode a chip pair: result[0] is the bit, result[1] flags a violation.
  function automatic logic [1:0] manch_decode(input logic first_chip, input logic second_chip);
    return {first_chip == second_chip, second_chip};
  endfunction

endpackage

// File: rtl/manch_tx.sv
module manch_tx
  import manch_codec_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int CHIPS = 2 * NIB_W,
  localparam int PH_W  = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] tx_nibble,
  output logic             tx_take,
  output logic             line_tx,
  output logic             tx_busy,
  output logic [PH_W-1:0]  tx_ph
);

  logic [NIB_W-1:0] sh_q;
  logic             last_chip;

  assign last_chip = tx_busy && (tx_ph == PH_W'(CHIPS - 1));
  assign tx_take   = tx_en && (!tx_busy || last_chip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_ph   <= '0;
      sh_q    <= '0;
    end else if (tx_take) begin
      sh_q    <= tx_nibble;
      tx_busy <= 1'b1;
      tx_ph   <= '0;
    end else if (last_chip) begin
      tx_busy <= 1'b0;
      tx_ph   <= '0;
    end else if (tx_busy) begin
      tx_ph   <= tx_ph + PH_W'(1);
    end
  end

  assign line_tx = tx_busy ? manch_chip(sh_q[tx_ph[PH_W-1:1]], tx_ph[0]) : 1'b0;

endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_codec_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int CHIPS = 2 * NIB_W,
  localparam int PH_W  = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic             rx_chip,
  output logic [NIB_W-1:0] rx_nibble,
  output logic             rx_valid,
  output logic             rx_err,
  output logic             rx_done,
  output logic             rx_viol
);

  logic [PH_W-1:0]  rph_q;
  logic             first_q;
  logic [NIB_W-1:0] asm_q, asm_n;
  logic             verr_q;
  logic [PH_W-1:0]  vcnt_q;
  logic [1:0]       dec;
  logic             pair_end;

  assign pair_end = rx_dv && rph_q[0];
  assign dec      = manch_decode(first_q, rx_chip);
  assign rx_viol  = pair_end && dec[1];
  assign rx_done  = pair_end && (rph_q == PH_W'(CHIPS - 1));

  always_comb begin
    asm_n = asm_q;
    asm_n[rph_q[PH_W-1:1]] = dec[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rph_q   <= '0;
      first_q <= 1'b0;
      asm_q   <= '0;
      verr_q  <= 1'b0;
    end else if (!rx_dv) begin
      rph_q   <= '0;
      verr_q  <= 1'b0;
    end else begin
      rph_q <= rx_done ? '0 : rph_q + PH_W'(1);
      if (!rph_q[0]) begin
        first_q <= rx_chip;
      end else begin
        asm_q  <= asm_n;
        verr_q <= rx_done ? 1'b0 : (verr_q | dec[1]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_nibble <= '0;
      rx_err    <= 1'b0;
      rx_valid  <= 1'b0;
      vcnt_q    <= '0;
    end else if (rx_done) begin
      rx_nibble <= asm_n;
      rx_err    <= verr_q | dec[1];
      rx_valid  <= 1'b1;
      vcnt_q    <= PH_W'(CHIPS - 1);
    end else if (rx_valid) begin
      if (vcnt_q == '0) rx_valid <= 1'b0;
      else              vcnt_q   <= vcnt_q - PH_W'(1);
    end
  end

endmodule

// File: rtl/manch_nibble_codec.sv
module manch_nibble_codec #(
  parameter int NIB_W = 4,
  localparam int CHIPS = 2 * NIB_W,
  localparam int PH_W  = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] tx_nibble,
  output logic             tx_take,
  output logic             line_tx,
  input  logic             rx_dv,
  input  logic             rx_chip,
  output logic [NIB_W-1:0] rx_nibble,
  output logic             rx_valid,
  output logic             rx_err
);

  logic            tx_busy;
  logic [PH_W-1:0] tx_ph;
  logic            rx_done;
  logic            rx_viol;

  manch_tx #(.NIB_W(NIB_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_nibble (tx_nibble),
    .tx_take   (tx_take),
    .line_tx   (line_tx),
    .tx_busy   (tx_busy),
    .tx_ph     (tx_ph)
  );

  manch_rx #(.NIB_W(NIB_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_dv),
    .rx_chip   (rx_chip),
    .rx_nibble (rx_nibble),
    .rx_valid  (rx_valid),
    .rx_err    (rx_err),
    .rx_done   (rx_done),
    .rx_viol   (rx_viol)
  );

endmodule

// File: rtl/manch_codec_checker.sv
module manch_codec_checker #(
  parameter int NIB_W = 4,
  localparam int CHIPS = 2 * NIB_W,
  localparam int PH_W  = $clog2(CHIPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_take,
  input logic             line_tx,
  input logic             tx_busy,
  input logic [PH_W-1:0]  tx_ph,
  input logic [NIB_W-1:0] rx_nibble,
  input logic             rx_valid,
  input logic             rx_err,
  input logic             rx_done,
  input logic             rx_viol
);

  assert_take_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_ph != PH_W'(CHIPS - 1)) |-> !tx_take);

  assert_take_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_take);

  assert_chip_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_ph[0]) |-> (line_tx != $past(line_tx)));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !line_tx);

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> (tx_busy && tx_ph == '0));

  assert_valid_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_done) |=> ($stable(rx_nibble) && $stable(rx_err)));

  assert_viol_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_viol && rx_done) |=> rx_err);

endmodule

bind manch_nibble_codec manch_codec_checker #(.NIB_W(NIB_W)) u_manch_codec_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .tx_take   (tx_take),
  .line_tx   (line_tx),
  .tx_busy   (tx_busy),
  .tx_ph     (tx_ph),
  .rx_nibble (rx_nibble),
  .rx_valid  (rx_valid),
  .rx_err    (rx_err),
  .rx_done   (rx_done),
  .rx_viol   (rx_viol)
);

// File: tb/test_manch_nibble_codec.sv
`timescale 1ns/1ps
module test_manch_nibble_codec;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en;
  logic [3:0] tx_nibble;
  logic       tx_take;
  logic       line_tx;
  logic       rx_dv;
  logic       rx_chip;
  logic [3:0] rx_nibble;
  logic       rx_valid;
  logic       rx_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [3:0] q [16];
  logic       cap [128];

  always #2.5 clk = ~clk;

  manch_nibble_codec i_manch_nibble_codec (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_nibble(tx_nibble),
    .tx_take(tx_take), .line_tx(line_tx), .rx_dv(rx_dv), .rx_chip(rx_chip),
    .rx_nibble(rx_nibble), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  // Expected chips of a nibble: bit 0 first, a 1 goes out as 0 then 1.
  function automatic logic [7:0] want_chips(input logic [3:0] nib);
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      v[2*b]   = (nib[b] == 1'b0);
      v[2*b+1] = (nib[b] == 1'b1);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_en = 1'b0;
      rx_dv = 1'b0;
      rx_chip = 1'(($urandom));
    end
  endtask

  // Transmit q[0..n-1] back to back with scribbling between boundaries.
  task automatic tx_burst(input int n);
    logic [7:0] got;
    for (int t = 0; t <= 8 * n; t++) begin
      @(negedge clk);
      if (t > 0) cap[t-1] = line_tx;
      if (t < 8 * n) begin
        tx_en = 1'b1;
        if (t % 8 == 0) tx_nibble = q[t/8];
        else            tx_nibble = 4'($urandom);
      end else begin
        tx_en = 1'b0;
      end
      #1;
      chk(tx_take == ((t % 8 == 0) && (t < 8 * n)), "R1 take timing", tx_take,
          int'((t % 8 == 0) && (t < 8 * n)));
    end
    for (int j = 0; j < n; j++) begin
      for (int c = 0; c < 8; c++) got[c] = cap[8*j+c];
      chk(got == want_chips(q[j]), "R2 R3 R5 R6 chips", got, want_chips(q[j]));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(line_tx == 1'b0 && tx_take == 1'b0, "R4 idle after burst", line_tx, 0);
    end
  endtask

  // Start one nibble and withdraw enable at chip 3.
  task automatic tx_drop(input logic [3:0] nib);
    logic [7:0] got;
    @(negedge clk);
    tx_en = 1'b1;
    tx_nibble = nib;
    for (int t = 1; t <= 8; t++) begin
      @(negedge clk);
      got[t-1] = line_tx;
      if (t == 3) begin
        tx_en = 1'b0;
        tx_nibble = ~nib;
      end
      #1;
      if (t >= 3) chk(tx_take == 1'b0, "R4 no take while disabled", tx_take, 0);
    end
    chk(got == want_chips(nib), "R4 full nibble after drop", got, want_chips(nib));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(line_tx == 1'b0, "R4 line idle low", line_tx, 0);
    end
  endtask

  // Receive q[0..n-1]; bit j of vmask injects a violation in nibble j bit 1.
  task automatic rx_burst(input int n, input int vmask);
    for (int t = 0; t <= 8 * n + 8; t++) begin
      @(negedge clk);
      if (t >= 1 && t <= 7)
        chk(rx_valid == 1'b0, "R8 R10 no early valid", rx_valid, 0);
      else if (t >= 8 && t < 8 * n + 8) begin
        chk(rx_valid == 1'b1, "R8 valid window", rx_valid, 1);
        chk(rx_nibble == q[t/8-1], "R7 R8 nibble", rx_nibble, q[t/8-1]);
        chk(rx_err == vmask[t/8-1], "R9 err flag", rx_err, vmask[t/8-1]);
      end else if (t == 8 * n + 8)
        chk(rx_valid == 1'b0, "R8 valid drops after 8", rx_valid, 0);
      if (t < 8 * n) begin
        rx_dv = 1'b1;
        rx_chip = want_chips(q[t/8])[t%8];
        if (vmask[t/8] && (t % 8 == 2)) rx_chip = q[t/8][1];
      end else begin
        rx_dv = 1'b0;
        rx_chip = 1'(($urandom));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; tx_en = 1'b0; tx_nibble = '0; rx_dv = 1'b0; rx_chip = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_tx == 1'b0 && tx_take == 1'b0, "R11 tx reset", {tx_take, line_tx}, 0);
    chk(rx_valid == 1'b0 && rx_err == 1'b0, "R11 rx flags reset", {rx_valid, rx_err}, 0);
    chk(rx_nibble == 4'h0, "R11 rx nibble reset", rx_nibble, 0);

    q[0] = 4'h0; q[1] = 4'hF; q[2] = 4'hA; q[3] = 4'h5;
    tx_burst(4);
    idle(2);
    for (int r = 0; r < 4; r++) begin
      int n = 1 + int'($urandom % 8);
      for (int j = 0; j < n; j++) q[j] = 4'($urandom);
      tx_burst(n);
      idle(1 + int'($urandom % 3));
    end
    tx_drop(4'h6);
    idle(2);

    q[0] = 4'h1; q[1] = 4'h8; q[2] = 4'hE; q[3] = 4'h3;
    rx_burst(4, 0);
    idle(2);
    q[0] = 4'h9; q[1] = 4'h9; q[2] = 4'h4;
    rx_burst(3, 32'b010);
    idle(2);
    for (int r = 0; r < 4; r++) begin
      int n = 1 + int'($urandom % 8);
      int vm = int'($urandom) & ((1 << n) - 1) & 32'h55;
      for (int j = 0; j < n; j++) q[j] = 4'($urandom);
      rx_burst(n, vm);
      idle(2);
    end

    // R10: partial nibble with a violation, then a framing gap.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_dv = 1'b1;
      rx_chip = 1'b1;
    end
    idle(2);
    chk(rx_valid == 1'b0, "R10 partial gives no valid", rx_valid, 0);
    q[0] = 4'hC;
    rx_burst(1, 0);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule